// File: doc/BRIEF.md
# SCL Phase Timer for a Mixed I3C/I2C Bus

This block drives the serial clock line of a mixed-speed bus controller. It divides the core clock into high and low SCL phases whose lengths come from four timing words, one for each bus mode: I3C push-pull, I3C open-drain, I2C Fast-mode and I2C Fast-mode Plus. In push-pull mode a per-transfer speed code can swap the low count for one of four slower-grade low counts packed in a fifth word, while the push-pull high count stays in use.

A start request begins clocking with a low phase. A stop request releases the line high at the next phase boundary. After a release the block holds SCL high for a programmed bus-free interval before any new start can take effect, and it keeps a start that arrives during that interval. A one-cycle strobe marks every SCL edge for the data path.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is asserted and after it is released with no start, `scl` is 1 and `phase_stb` is 0.
- R2: A start sampled while idle makes `scl` low from the next clock edge on. A low phase lasts the selected low count plus one core cycles.
- R3: A high phase lasts the selected high count plus one core cycles. Phases alternate low and high until a stop is honoured.
- R4: `bus_mode` selects the count source. 0 is push-pull, with high in `tm_pp[23:16]` and low in `tm_pp[7:0]`. 1 is open-drain, with high in `tm_od[23:16]` and low in `tm_od[7:0]`. 2 is Fast-mode, with high in `tm_fm[31:16]` and low in `tm_fm[15:0]`. 3 is Fast-mode Plus, with high in `tm_fmp[23:16]` and low in `tm_fmp[15:0]`. All other bits are ignored.
- R5: In mode 0, `speed` codes 1, 2, 3 and 4 take the low count from `tm_ext` byte 0, 1, 2 and 3 (bits [7:0], [15:8], [23:16], [31:24]). Codes 0 and 5 to 7 use `tm_pp[7:0]`. The high count stays `tm_pp[23:16]`. `speed` has no effect in modes 1 to 3.
- R6: Any selected high or low count below 5 is used as 5, so every phase lasts at least 6 cycles.
- R7: A count is taken when its phase begins. Changing a timing input during a phase alters only later phases.
- R8: `phase_stb` is 1 for exactly the first cycle after each change of `scl` and is 0 in every other cycle.
- R9: A stop while running is honoured at the end of the current phase. A low phase still runs its full length, then `scl` goes high and stays high. A stop at the end of a high phase leaves `scl` high with no edge.
- R10: After a stop release, `scl` stays high for `free_cnt` plus one cycles at least. A start that is held, or pulsed at any time in that interval, makes `scl` fall exactly `free_cnt` plus one cycles after it rose.
- R11: A start while running has no effect on the phase lengths. A stop while idle has no effect, so a later start runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tm_pp | input | 32 | Push-pull timing word |
| tm_od | input | 32 | Open-drain timing word |
| tm_fm | input | 32 | Fast-mode timing word |
| tm_fmp | input | 32 | Fast-mode Plus timing word |
| tm_ext | input | 32 | Four 8-bit slower-grade low counts |
| free_cnt | input | 16 | Bus-free interval in core cycles |
| bus_mode | input | 2 | Mode select (0 push-pull, 1 open-drain, 2 FM, 3 FM+) |
| speed | input | 3 | Per-transfer speed code |
| start | input | 1 | Start request |
| stop | input | 1 | Stop request |
| scl | output | 1 | SCL level |
| phase_stb | output | 1 | One-cycle strobe after each SCL edge |

## Verification
The main timing path is tried under every mode and under each speed code. The timing words are filled with distinct values in their used fields and with non-zero junk in the unused bits. Each measured pair of phase lengths therefore shows which field was picked. A wrong lane, a wrong fallback for the spare codes, or a leak of the speed code into the non-push-pull modes gives a different count. Counts below the floor tell a clamped comparison from a raw one. A timing word rewritten mid-phase tells apart latching at the boundary from live use. Stops placed in low and high phases, with held and pulsed starts during a non-zero bus-free wait, separate boundary-aligned release from an immediate one and show whether a pending start is lost.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int CW      = 16,
  parameter int FW      = 16,
  parameter int MIN_CNT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   tm_pp,
  input  logic [31:0]   tm_od,
  input  logic [31:0]   tm_fm,
  input  logic [31:0]   tm_fmp,
  input  logic [31:0]   tm_ext,
  input  logic [FW-1:0] free_cnt,
  input  logic [1:0]    bus_mode,
  input  logic [2:0]    speed,
  input  logic          start,
  input  logic          stop,
  output logic          scl,
  output logic          phase_stb
);

  localparam logic [1:0]    S_IDLE = 2'd0;
  localparam logic [1:0]    S_RUN  = 2'd1;
  localparam logic [1:0]    S_FREE = 2'd2;
  localparam logic [CW-1:0] MINV   = CW'(MIN_CNT);

  logic [1:0]    st;
  logic [CW-1:0] pcnt, plen;
  logic [FW-1:0] fcnt, flen;
  logic          start_pend, stop_pend;
  logic [CW-1:0] hi_raw, lo_raw, hi_cnt, lo_cnt;
  logic [7:0]    pp_lo;

  logic unused_bits;
  assign unused_bits = ^{tm_pp[31:24], tm_pp[15:8], tm_od[31:24], tm_od[15:8], tm_fmp[31:24]};

  always_comb begin
    case (speed)
      3'd1:    pp_lo = tm_ext[7:0];
      3'd2:    pp_lo = tm_ext[15:8];
      3'd3:    pp_lo = tm_ext[23:16];
      3'd4:    pp_lo = tm_ext[31:24];
      default: pp_lo = tm_pp[7:0];
    endcase
  end

  always_comb begin
    case (bus_mode)
      2'd0: begin hi_raw = CW'(tm_pp[23:16]);  lo_raw = CW'(pp_lo);         end
      2'd1: begin hi_raw = CW'(tm_od[23:16]);  lo_raw = CW'(tm_od[7:0]);    end
      2'd2: begin hi_raw = CW'(tm_fm[31:16]);  lo_raw = CW'(tm_fm[15:0]);   end
      default: begin hi_raw = CW'(tm_fmp[23:16]); lo_raw = CW'(tm_fmp[15:0]); end
    endcase
  end

  assign hi_cnt = (hi_raw < MINV) ? MINV : hi_raw;
  assign lo_cnt = (lo_raw < MINV) ? MINV : lo_raw;

  wire stop_now  = stop_pend | stop;
  wire start_now = start_pend | start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      scl        <= 1'b1;
      phase_stb  <= 1'b0;
      pcnt       <= '0;
      plen       <= MINV;
      fcnt       <= '0;
      flen       <= '0;
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
    end else begin
      phase_stb <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            st        <= S_RUN;
            scl       <= 1'b0;
            phase_stb <= 1'b1;
            pcnt      <= '0;
            plen      <= lo_cnt;
            stop_pend <= 1'b0;
          end
        end
        S_RUN: begin
          stop_pend <= stop_now;
          if (pcnt == plen) begin
            pcnt <= '0;
            if (stop_now) begin
              st         <= S_FREE;
              fcnt       <= '0;
              flen       <= free_cnt;
              start_pend <= 1'b0;
              stop_pend  <= 1'b0;
              if (!scl) begin
                scl       <= 1'b1;
                phase_stb <= 1'b1;
              end
            end else begin
              scl       <= ~scl;
              phase_stb <= 1'b1;
              plen      <= scl ? lo_cnt : hi_cnt;
            end
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: begin
          if (fcnt >= flen) begin
            start_pend <= 1'b0;
            if (start_now) begin
              st        <= S_RUN;
              scl       <= 1'b0;
              phase_stb <= 1'b1;
              pcnt      <= '0;
              plen      <= lo_cnt;
              stop_pend <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            fcnt       <= fcnt + 1'b1;
            start_pend <= start_now;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk #(
  parameter int CW      = 16,
  parameter int MIN_CNT = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl,
  input logic          phase_stb,
  input logic [1:0]    st,
  input logic [CW-1:0] pcnt,
  input logic [CW-1:0] plen
);

  p_stb_after_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_stb |-> (scl != $past(scl)));

  p_edge_has_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl != $past(scl)) |-> phase_stb);

  p_cnt_in_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (pcnt <= plen));

  p_len_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1) |-> (plen >= CW'(MIN_CNT)));

  p_len_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && $past(st) == 2'd1 && !phase_stb) |-> $stable(plen));

  p_released_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != 2'd1) |-> scl);

endmodule

bind scl_rate_gen scl_rate_gen_chk #(.CW(CW), .MIN_CNT(MIN_CNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .phase_stb(phase_stb),
  .st(st), .pcnt(pcnt), .plen(plen)
);

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tm_pp, tm_od, tm_fm, tm_fmp, tm_ext;
  logic [15:0] free_cnt;
  logic [1:0]  bus_mode;
  logic [2:0]  speed;
  logic        start, stop;
  logic        scl, phase_stb;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  scl_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .tm_pp(tm_pp), .tm_od(tm_od), .tm_fm(tm_fm),
    .tm_fmp(tm_fmp), .tm_ext(tm_ext), .free_cnt(free_cnt), .bus_mode(bus_mode),
    .speed(speed), .start(start), .stop(stop), .scl(scl), .phase_stb(phase_stb)
  );

  localparam int NV = 12;
  localparam int V_MODE [NV] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 2, 3, 3};
  localparam int V_SPD  [NV] = '{0, 1, 2, 3, 4, 5, 7, 0, 3, 0, 0, 2};
  localparam int V_LO   [NV] = '{10, 12, 14, 18, 6, 10, 10, 13, 13, 26, 16, 16};
  localparam int V_HI   [NV] = '{8, 8, 8, 8, 8, 8, 8, 7, 7, 21, 11, 11};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(input logic lvl, output int n, output int sok);
    n = 0;
    sok = 1;
    while (scl === lvl && n < 4000) begin
      if ((n == 0) != (phase_stb === 1'b1)) sok = 0;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic stop_and_settle();
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  initial begin
    #1ms;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n, n2, sok, sok2, hold;
    tm_pp = 32'hAB07_CD09;
    tm_od = 32'hFF06_EE0C;
    tm_fm = 32'h0014_0019;
    tm_fmp = 32'hFF0A_000F;
    tm_ext = 32'h0311_0D0B;
    free_cnt = 16'd0;
    bus_mode = 2'd0;
    speed = 3'd0;
    start = 1'b0;
    stop = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 scl in reset", int'(scl), 1);
    check("R1 strobe in reset", int'(phase_stb), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 scl after reset", int'(scl), 1);
    check("R1 strobe after reset", int'(phase_stb), 0);

    // R2 R3 R4 R5 R8: table of mode / speed against phase lengths
    for (int i = 0; i < NV; i++) begin
      bus_mode = V_MODE[i][1:0];
      speed = V_SPD[i][2:0];
      pulse_start();
      meas(1'b0, n, sok);
      check($sformatf("R2 R4 R5 low len vec %0d", i), n, V_LO[i]);
      meas(1'b1, n2, sok2);
      check($sformatf("R3 R4 R5 high len vec %0d", i), n2, V_HI[i]);
      check($sformatf("R8 strobe vec %0d", i), sok & sok2, 1);
      stop_and_settle();
    end

    // R6: counts below the floor
    bus_mode = 2'd0;
    speed = 3'd0;
    tm_pp = 32'h0000_0002;
    pulse_start();
    meas(1'b0, n, sok);
    check("R6 floored low", n, 6);
    meas(1'b1, n, sok);
    check("R6 floored high", n, 6);
    stop_and_settle();
    tm_pp = 32'hAB07_CD09;

    // R7: mid-phase change affects only later phases
    pulse_start();
    n = 0;
    while (scl === 1'b0 && n < 4000) begin
      n++;
      if (n == 3) tm_pp = 32'hAB07_CD14;
      @(negedge clk);
    end
    check("R7 current low kept", n, 10);
    meas(1'b1, n, sok);
    check("R7 high", n, 8);
    meas(1'b0, n, sok);
    check("R7 next low uses new count", n, 21);
    stop_and_settle();
    tm_pp = 32'hAB07_CD09;

    // R9: stop during low phase
    pulse_start();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    n = 2;
    while (scl === 1'b0 && n < 4000) begin n++; @(negedge clk); end
    check("R9 low phase completes", n, 10);
    hold = 0;
    for (int k = 0; k < 50; k++) begin
      if (scl !== 1'b1) hold++;
      @(negedge clk);
    end
    check("R9 stays high after stop", hold, 0);

    // R9: stop during high phase, no edge at release
    pulse_start();
    meas(1'b0, n, sok);
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    hold = 0;
    for (int k = 0; k < 50; k++) begin
      if (scl !== 1'b1 || (k > 0 && phase_stb !== 1'b0)) hold++;
      @(negedge clk);
    end
    check("R9 high-phase stop holds high", hold, 0);

    // R10: bus-free wait with held start
    free_cnt = 16'd20;
    pulse_start();
    @(negedge clk);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    while (scl === 1'b0) @(negedge clk);
    start = 1'b1;
    meas(1'b1, n, sok);
    start = 1'b0;
    check("R10 free wait held start", n, 21);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    while (scl === 1'b0) @(negedge clk);
    // pulsed start early in the wait
    @(negedge clk);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    meas(1'b1, n, sok);
    check("R10 pulsed start kept pending", n + 3, 21);
    stop_and_settle();
    free_cnt = 16'd0;

    // R11: start while running ignored
    pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 2;
    while (scl === 1'b0 && n < 4000) begin n++; @(negedge clk); end
    check("R11 start while running", n, 10);
    meas(1'b1, n, sok);
    check("R11 high after ignored start", n, 8);
    stop_and_settle();

    // R11: stop while idle ignored
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    @(negedge clk);
    check("R11 idle stop scl", int'(scl), 1);
    pulse_start();
    meas(1'b0, n, sok);
    check("R11 low after idle stop", n, 10);
    meas(1'b1, n, sok);
    check("R11 high after idle stop", n, 8);
    stop_and_settle();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule